// File: doc/BRIEF.md
# SPI Master Frame Shifter

This block is a serial master that turns one parallel word into one SPI frame and collects the word clocked back in during that same frame. It runs entirely on the system clock. The serial clock comes from a half-period timer rather than a second clock domain. The block drives the serial clock, an active-low frame select and the serial data output, and it samples the serial data input.

The idle level of the serial clock and the phase of the sampling edge are programmable. A loopback option feeds the transmit shifter output straight into the receive shifter. The word, the frame length, the divider and the mode bits are offered with a valid/ready handshake. All of them are captured when the word is accepted. At the end of every frame the received word appears with a one-cycle strobe.

The controller has five states:
- **IDLE**: ready for a word.
- **LEAD**: select is low and the clock is still quiet.
- **SHIFT**: the clock toggles once per half period, for two halves per bit.
- **TAIL**: an extra quiet half, used only when phase is 1.
- **GAP**: select is high for one bit period.

The transitions are:
- IDLE→LEAD on accept.
- LEAD→SHIFT after its quiet halves.
- SHIFT→TAIL when phase is 1, or SHIFT→GAP when phase is 0, after the last half.
- TAIL→GAP after one half.
- GAP→IDLE after two halves.

Top module: `spi_frame_shifter`

## Requirements
- R1: After reset, and between frames, `sel_n` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: Whenever no bit is being clocked, `sclk` rests at the polarity level. In IDLE it follows the `cpol` input: 0 means low and 1 means high.
- R3: With `cpha`=0, the first `sclk` edge comes 2×(`clk_div`+1) clocks after `sel_n` falls. `sel_n` rises (`clk_div`+1) clocks after the last `sclk` edge.
- R4: With `cpha`=1, the first `sclk` edge comes (`clk_div`+1) clocks after `sel_n` falls. `sel_n` rises 2×(`clk_div`+1) clocks after the last `sclk` edge.
- R5: Each clock half lasts `clk_div`+1 system clocks. A frame of N bits has exactly N leading edges, and `sel_n` stays low for (2N+2)×(`clk_div`+1) clocks.
- R6: Bits leave on `sdo` MSB first. Bit k of the frame is stable on `sdo` at the sampling edge, which is the leading edge when `cpha`=0 and the trailing edge when `cpha`=1. A leading edge is a transition away from the idle level.
- R7: The received word is right-justified in `rx_data`, with the first received bit at position N-1. `rx_valid` is high for exactly one clock, in the same cycle that `sel_n` rises.
- R8: With `loopback`=1, the received word equals the transmitted word masked to N bits, whatever `sdi` does.
- R9: `busy` is 1 from acceptance until the end of GAP, and `tx_ready` is 1 only when `busy` is 0.
- R10: Between consecutive frames, `sel_n` stays high for at least 2×(`clk_div`+1) clocks of the earlier frame.
- R11: A `frame_len` below 4 gives a 4-bit frame, and a value above MAX_BITS gives a MAX_BITS-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | MAX_BITS | Word to send, right-justified |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Block can accept a word |
| clk_div | input | DIV_W | Half-period length minus one |
| frame_len | input | LEN_W | Bits per frame (clamped to 4..MAX_BITS) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| loopback | input | 1 | Route sdo internally to the receive shifter |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sel_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data out |
| rx_data | output | MAX_BITS | Received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe with a new received word |
| busy | output | 1 | Frame or inter-frame gap in progress |

## Verification
The bench builds the block with its defaults: MAX_BITS=16 and DIV_W=8. With MAX_BITS=16, the full 4..16 length range and both clamp directions can be reached. Divider values 0 to 3 keep frames short, while still separating one-clock halves from multi-clock halves in the lead and tail timing. All four polarity/phase combinations, loopback with a conflicting `sdi`, and back-to-back frames are sent. A bench slave answers on the correct edges for each mode.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } fs_state_e;

    localparam int MIN_FRAME_BITS = 4;

endpackage

// File: rtl/spi_fs_half_timer.sv
module spi_fs_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == limit);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit)); // R5

endmodule

// File: rtl/spi_fs_tx_shift.sv
module spi_fs_tx_shift #(
    parameter int MAX_BITS = 16,
    localparam int LEN_W = $clog2(MAX_BITS + 1),
    localparam int IDX_W = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [MAX_BITS-1:0] data,
    input  logic [LEN_W-1:0]    len,
    output logic                sdo
);

    logic [MAX_BITS-1:0] sh;
    logic [LEN_W-1:0]    shamt;
    logic [IDX_W-1:0]    top_idx;
    logic                top_bit;

    always_comb begin
        shamt   = LEN_W'(MAX_BITS) - len;
        top_idx = IDX_W'(len - 1'b1);
        top_bit = data[top_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= data << shamt;
        end else if (shift) begin
            sh <= {sh[MAX_BITS-2:0], 1'b0};
        end
    end

    assign sdo = sh[MAX_BITS-1];

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdo == $past(top_bit))); // R6

endmodule

// File: rtl/spi_fs_rx_shift.sv
module spi_fs_rx_shift #(
    parameter int MAX_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic                din,
    output logic [MAX_BITS-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (sample) begin
            word <= {word[MAX_BITS-2:0], din};
        end
    end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_fs_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int DIV_W = 8,
    localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [DIV_W-1:0]    clk_div,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic                cpol,
    input  logic                cpha,
    input  logic                loopback,
    input  logic                sdi,
    output logic                sclk,
    output logic                sel_n,
    output logic                sdo,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                busy
);

    localparam int HC_W  = $clog2(2 * MAX_BITS + 2);
    localparam int GAP_W = DIV_W + 3;

    fs_state_e state, state_nx;

    logic [HC_W-1:0]     hc;
    logic [DIV_W-1:0]    div_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    len_clamped;
    logic                cpol_q, cpha_q, lb_q;
    logic                tick, accept;
    logic                lead_last, shift_last;
    logic                sample_ev, shift_ev, done_ev;
    logic                din;
    logic [MAX_BITS-1:0] rx_word;

    assign accept = tx_valid && (state == ST_IDLE);

    always_comb begin
        if (frame_len < LEN_W'(MIN_FRAME_BITS)) begin
            len_clamped = LEN_W'(MIN_FRAME_BITS);
        end else if (frame_len > LEN_W'(MAX_BITS)) begin
            len_clamped = LEN_W'(MAX_BITS);
        end else begin
            len_clamped = frame_len;
        end
    end

    spi_fs_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .limit (div_q),
        .tick  (tick)
    );

    assign lead_last  = cpha_q ? (hc == HC_W'(0)) : (hc == HC_W'(1));
    assign shift_last = (hc == (HC_W'(len_q) << 1) - HC_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tx_valid) state_nx = ST_LEAD;
            ST_LEAD:  if (tick && lead_last) state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && shift_last) state_nx = cpha_q ? ST_TAIL : ST_GAP;
            ST_TAIL:  if (tick) state_nx = ST_GAP;
            ST_GAP:   if (tick && hc == HC_W'(1)) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc <= '0;
        end else if (state_nx != state) begin
            hc <= '0;
        end else if (tick) begin
            hc <= hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            len_q  <= LEN_W'(MIN_FRAME_BITS);
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            lb_q   <= 1'b0;
        end else if (accept) begin
            div_q  <= clk_div;
            len_q  <= len_clamped;
            cpol_q <= cpol;
            cpha_q <= cpha;
            lb_q   <= loopback;
        end
    end

    // Edge bookkeeping: an odd hc tick enters an active half (leading edge),
    // an even hc tick enters a quiet half (trailing edge).
    assign sample_ev = tick && (
        (state == ST_LEAD && lead_last && !cpha_q) ||
        (state == ST_SHIFT && !shift_last && (hc[0] ? !cpha_q : cpha_q)));
    assign shift_ev = tick && (state == ST_SHIFT) && !shift_last &&
                      (hc[0] ? cpha_q : !cpha_q);
    assign done_ev = tick && ((state == ST_SHIFT && shift_last && !cpha_q) ||
                              state == ST_TAIL);

    spi_fs_tx_shift #(.MAX_BITS(MAX_BITS)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (shift_ev),
        .data  (tx_data),
        .len   (len_clamped),
        .sdo   (sdo)
    );

    assign din = lb_q ? sdo : sdi;

    spi_fs_rx_shift #(.MAX_BITS(MAX_BITS)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (sample_ev),
        .din    (din),
        .word   (rx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= done_ev;
            if (done_ev) rx_data <= rx_word;
        end
    end

    always_comb begin
        sel_n    = 1'b1;
        sclk     = cpol_q;
        busy     = 1'b1;
        tx_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                sclk     = cpol;
                busy     = 1'b0;
                tx_ready = 1'b1;
            end
            ST_LEAD, ST_TAIL: sel_n = 1'b0;
            ST_SHIFT: begin
                sel_n = 1'b0;
                sclk  = cpol_q ^ ~hc[0];
            end
            ST_GAP: sel_n = 1'b1;
            default: sel_n = 1'b1;
        endcase
    end

    // Checker state: clocks spent with select high, saturating.
    logic [GAP_W-1:0] gap_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '1;
        end else if (!sel_n) begin
            gap_cnt <= '0;
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !busy); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (sel_n && !$past(sel_n))); // R7
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> (int'(gap_cnt) >= 2 * (int'($past(div_q)) + 1))); // R10
    AST_SCLK_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && $past(state) == ST_GAP) |-> $stable(sclk)); // R2

endmodule

// File: tb/spi_frame_shifter_tb_top.sv
module spi_frame_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  clk_div = '0;
    logic [4:0]  frame_len = 5'd8;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        loopback = 1'b0;
    logic        sdi = 1'b0;
    logic        sclk, sel_n, sdo, rx_valid, busy;
    logic [15:0] rx_data;

    always #5 clk = ~clk;

    spi_frame_shifter #(.MAX_BITS(16), .DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .clk_div(clk_div), .frame_len(frame_len),
        .cpol(cpol), .cpha(cpha), .loopback(loopback), .sdi(sdi),
        .sclk(sclk), .sel_n(sel_n), .sdo(sdo), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        bit          pol;
        bit          pha;
        bit          lb;
        int          n;
        int          div;
        logic [15:0] slv;
        logic [15:0] exp_rx;
        logic [15:0] exp_tx;
    } frm_t;

    frm_t frm_q[$];
    frm_t cur;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: pushes the expected frame, then offers the word.
    task automatic send(input logic [15:0] w, input int flen, input int div,
                        input bit pol, input bit pha, input bit lb,
                        input logic [15:0] slv);
        frm_t f;
        int n;
        logic [15:0] m;
        n = (flen < 4) ? 4 : ((flen > 16) ? 16 : flen); // R11 clamp
        m = 16'((32'h1 << n) - 1);
        f.pol = pol; f.pha = pha; f.lb = lb; f.n = n; f.div = div; f.slv = slv;
        f.exp_rx = lb ? (w & m) : (slv & m);
        f.exp_tx = w & m;
        frm_q.push_back(f);
        @(negedge clk);
        tx_data = w; frame_len = 5'(flen); clk_div = 8'(div);
        cpol = pol; cpha = pha; loopback = lb; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Monitor and bench slave.
    bit prev_sel = 1'b1, in_frame = 1'b0, seen_rise = 1'b0, pulse_chk = 1'b0;
    bit psclk, bad_half, bad_busy, lead;
    int fall_cyc, rise_cyc, e1, last_e, n_edges, n_lead, sbit, last_div;
    logic [15:0] cap;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && !sel_n && prev_sel) begin
            if (frm_q.size() == 0) begin
                chk(1'b0, "R9", "frame without request", 0, 1);
            end else begin
                cur = frm_q.pop_front();
            end
            if (seen_rise)
                chk(cyc - rise_cyc >= 2 * (last_div + 1), "R10", "gap clocks",
                    cyc - rise_cyc, 2 * (last_div + 1));
            fall_cyc = cyc; n_edges = 0; n_lead = 0; bad_half = 0; bad_busy = 0;
            cap = '0; sbit = cur.n - 1; in_frame = 1'b1; psclk = sclk;
            if (!cur.pha) begin
                sdi = cur.slv[sbit];
                sbit--;
            end
        end else if (!sel_n && in_frame) begin
            if (!busy) bad_busy = 1'b1;
            if (sclk !== psclk) begin
                lead = (sclk != cur.pol);
                if (n_edges == 0) e1 = cyc;
                else if (cyc - last_e != cur.div + 1) bad_half = 1'b1;
                n_edges++;
                last_e = cyc;
                if (lead) n_lead++;
                if (lead != cur.pha) begin
                    cap = {cap[14:0], sdo};
                end else if (sbit >= 0) begin
                    sdi = cur.slv[sbit];
                    sbit--;
                end
            end
            psclk = sclk;
        end
        if (sel_n && !prev_sel && in_frame) begin
            int h;
            h = cur.div + 1;
            chk(e1 - fall_cyc == (cur.pha ? 1 : 2) * h, cur.pha ? "R4" : "R3",
                "lead clocks", e1 - fall_cyc, (cur.pha ? 1 : 2) * h);
            chk(cyc - last_e == (cur.pha ? 2 : 1) * h, cur.pha ? "R4" : "R3",
                "tail clocks", cyc - last_e, (cur.pha ? 2 : 1) * h);
            chk(cyc - fall_cyc == (2 * cur.n + 2) * h, "R5", "select low clocks",
                cyc - fall_cyc, (2 * cur.n + 2) * h);
            chk(n_lead == cur.n, "R5", "leading edges", n_lead, cur.n);
            chk(!bad_half, "R5", "half period", bad_half, 0);
            chk(!bad_busy, "R9", "busy during frame", bad_busy, 0);
            chk(cap == cur.exp_tx, "R6", "sdo bits MSB first", cap, cur.exp_tx);
            chk(rx_valid == 1'b1, "R7", "rx_valid at select rise", rx_valid, 1);
            chk(rx_data == cur.exp_rx, cur.lb ? "R8" : "R7", "rx_data",
                rx_data, cur.exp_rx);
            in_frame = 1'b0; rise_cyc = cyc; seen_rise = 1'b1;
            last_div = cur.div; pulse_chk = 1'b1;
        end else if (pulse_chk) begin
            chk(!rx_valid, "R7", "rx_valid one clock", rx_valid, 0);
            chk(busy, "R9", "busy during gap", busy, 1);
            pulse_chk = 1'b0;
        end
        prev_sel = sel_n;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sel_n == 1'b1, "R1", "reset sel_n", sel_n, 1);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(tx_ready == 1'b1, "R1", "reset tx_ready", tx_ready, 1);
        chk(sclk == 1'b0, "R2", "idle sclk cpol=0", sclk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R2", "idle sclk cpol=1", sclk, 1);

        send(16'h00A5, 8, 1, 1'b0, 1'b0, 1'b0, 16'h003C);
        send(16'h005A, 8, 0, 1'b0, 1'b1, 1'b0, 16'h00C3);
        send(16'hBEEF, 16, 2, 1'b1, 1'b0, 1'b0, 16'h1234);
        send(16'h0ABC, 12, 3, 1'b1, 1'b1, 1'b0, 16'h0F0F);
        repeat (30) @(negedge clk);
        send(16'h0009, 4, 0, 1'b0, 1'b0, 1'b0, 16'h0006);
        send(16'hC0DE, 16, 1, 1'b1, 1'b1, 1'b1, 16'h5555); // R8 loopback
        send(16'h0033, 6, 0, 1'b0, 1'b1, 1'b1, 16'h002A); // R8 loopback
        send(16'hFFF7, 2, 0, 1'b0, 1'b0, 1'b0, 16'h000B); // R11 low clamp
        send(16'h8001, 25, 0, 1'b1, 1'b0, 1'b0, 16'hA5C3); // R11 high clamp

        while (frm_q.size() != 0 || in_frame || busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sel_n == 1'b1, "R1", "final sel_n", sel_n, 1);
        chk(tx_ready == 1'b1, "R1", "final tx_ready", tx_ready, 1);
        chk(sclk == cpol, "R2", "final idle sclk", sclk, cpol);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule